// File: doc/BRIEF.md
# Bit-Serial Lowest-Priority Arbitration Agent

One agent sits at each node of a shared two-wire interrupt bus and takes part in the arbitration part of a 34-cycle message that goes to the node with the lowest priority. An external strobe marks each bus cycle, and a start flag on a strobe marks cycle 1 of a new message. The agent counts cycles from that start. It does nothing before cycle 21.

In cycles 21 to 32 a participating agent sends a 12-bit pattern on wire 0, most significant bit first. The pattern is its priority, inverted, followed by its arbitration ID. The bus resolves as a wired-OR of all drivers. An agent that drives 0 while the bus reads 1 has lost, and it stays off the bus until the message ends. The survivor has the largest pattern, so it is the node with the lowest priority, and among equal priorities the one with the highest ID. The survivor raises `win_o` and drives the status cycle, cycle 33.

If nothing is driven in cycle 33, no node had a free slot. Every agent then raises `reject_o` so that the sender retries later. An error seen in cycle 33 sets a sticky accept-error flag. Cycle 34 is idle, and after it the agent waits for the next start.

Top module: `lp_arb_agent`

## Requirements
- R1: After reset, `bus_drv_o` is 2'b00 and `win_o`, `reject_o` and `accept_err_o` are all 0.
- R2: A strobe with `msg_start_i` high begins cycle 1, and each later strobe advances the cycle count by one. Both wires read 00 in cycles 1 to 20 and in cycle 34.
- R3: During cycles 21 to 28 a participating agent drives bit 7 down to bit 0 of `~prio_i` on wire 0. During cycles 29 to 32 it drives bit 3 down to bit 0 of `arb_id_i` on wire 0. Wire 1 stays 0 in all of cycles 21 to 32.
- R4: An agent that drives 0 on wire 0 while `bus_i[0]` is 1 at the strobe ending an arbitration cycle stops driving for the rest of the message. As a result the resolved wire 0 carries the largest {~priority, ID} among the participants. `win_o` is set at the strobe ending cycle 32 for the agent still driving, and it is held until the next start.
- R5: An agent whose `free_slot_i` is 0 when cycle 21 begins drives 00 in cycles 21 to 33 and does not win.
- R6: The winner drives 2'b11 during cycle 33. Every other agent drives 2'b00 in that cycle.
- R7: If `bus_i` is 2'b00 at the strobe ending cycle 33, `reject_o` is set. It is held until the next start.
- R8: If `accept_err_i` is high at the strobe ending cycle 33, `accept_err_o` is set. It stays set until reset, across later messages.
- R9: Priority, ID and free-slot flag are sampled at the strobe that begins cycle 21. Changes to them later in the message have no effect on the bus or on the outcome.
- R10: A start strobe at any point restarts the count at cycle 1 and clears `win_o` and `reject_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_stb_i | input | 1 | One-clock strobe per bus cycle |
| msg_start_i | input | 1 | Marks the strobe that begins cycle 1 |
| free_slot_i | input | 1 | Node has a free interrupt slot |
| prio_i | input | PRIO_W | Processor priority |
| arb_id_i | input | ID_W | Unique arbitration ID |
| bus_i | input | 2 | Resolved bus value |
| accept_err_i | input | 1 | Error detected in the status cycle |
| bus_drv_o | output | 2 | This node's bus drive |
| win_o | output | 1 | Node won the arbitration |
| reject_o | output | 1 | No node took the message |
| accept_err_o | output | 1 | Sticky accept error |

## Verification
The assertions assume three things about the inputs. `bus_i` is the wired-OR of every node's drive, including this node's own. Arbitration IDs are unique. The strobe is at most one clock wide. The bench builds the bus by OR-ing four agents' drives, derives the four IDs from one random base with a stride of 3 so they never collide, and spaces the strobes two clocks apart. It scrambles the priorities, IDs and free-slot flags in the middle of arbitration, and it restarts a message part way through, to show that neither disturbs the sampled values or the outcome.

// File: rtl/lp_arb_pkg.sv
package lp_arb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HEAD,
    PH_ARB,
    PH_STAT,
    PH_TAIL
  } phase_e;
endpackage

// File: rtl/lp_arb_cycle.sv
module lp_arb_cycle
  import lp_arb_pkg::*;
#(
  parameter int ARB_FIRST = 21,
  parameter int ARB_BITS  = 12
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bit_stb_i,
  input  logic   msg_start_i,
  output phase_e phase_o,
  output logic   arm_o,
  output logic   arb_stb_o,
  output logic   arb_end_o,
  output logic   stat_end_o,
  output logic   clr_o
);
  localparam int ARB_LAST = ARB_FIRST + ARB_BITS - 1;
  localparam int STAT_CYC = ARB_LAST + 1;
  localparam int TAIL_CYC = STAT_CYC + 1;
  localparam int CYC_W    = $clog2(TAIL_CYC + 1);
  localparam logic [CYC_W-1:0] C_ONE  = CYC_W'(1);
  localparam logic [CYC_W-1:0] C_ARM  = CYC_W'(ARB_FIRST - 1);
  localparam logic [CYC_W-1:0] C_FST  = CYC_W'(ARB_FIRST);
  localparam logic [CYC_W-1:0] C_LST  = CYC_W'(ARB_LAST);
  localparam logic [CYC_W-1:0] C_STAT = CYC_W'(STAT_CYC);
  localparam logic [CYC_W-1:0] C_TAIL = CYC_W'(TAIL_CYC);

  logic [CYC_W-1:0] cyc_q;
  logic             adv;

  assign adv   = bit_stb_i && !msg_start_i;
  assign clr_o = bit_stb_i && msg_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
    end else if (clr_o) begin
      cyc_q <= C_ONE;
    end else if (adv && cyc_q != '0) begin
      cyc_q <= (cyc_q == C_TAIL) ? '0 : cyc_q + C_ONE;
    end
  end

  always_comb begin
    if (cyc_q == '0)         phase_o = PH_IDLE;
    else if (cyc_q < C_FST)  phase_o = PH_HEAD;
    else if (cyc_q <= C_LST) phase_o = PH_ARB;
    else if (cyc_q == C_STAT) phase_o = PH_STAT;
    else                     phase_o = PH_TAIL;
  end

  assign arm_o      = adv && cyc_q == C_ARM;
  assign arb_stb_o  = adv && phase_o == PH_ARB;
  assign arb_end_o  = adv && cyc_q == C_LST;
  assign stat_end_o = adv && phase_o == PH_STAT;

  // R2
  cyc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q <= C_TAIL);
  // R2
  cyc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_i |=> $stable(cyc_q));
  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> phase_o == PH_HEAD);
endmodule

// File: rtl/lp_arb_serial.sv
module lp_arb_serial #(
  parameter int PRIO_W = 8,
  parameter int ID_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              arm_i,
  input  logic              arb_stb_i,
  input  logic              arb_end_i,
  input  logic              in_arb_i,
  input  logic              free_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              bus0_i,
  output logic              drv_o,
  output logic              win_o
);
  localparam int BITS = PRIO_W + ID_W;

  logic [BITS-1:0] sh_q;
  logic            active_q;
  logic            win_q;
  logic            lose;

  // losing: drove 0, saw 1
  assign lose  = active_q && !sh_q[BITS-1] && bus0_i;
  assign drv_o = in_arb_i && active_q && sh_q[BITS-1];
  assign win_o = win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      active_q <= 1'b0;
      win_q    <= 1'b0;
    end else if (clr_i) begin
      active_q <= 1'b0;
      win_q    <= 1'b0;
    end else if (arm_i) begin
      sh_q     <= {~prio_i, id_i};
      active_q <= free_i;
    end else if (arb_stb_i) begin
      sh_q <= {sh_q[BITS-2:0], 1'b0};
      if (lose) active_q <= 1'b0;
      if (arb_end_i) win_q <= active_q && !lose;
    end
  end

  // R4
  loser_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_arb_i && !active_q |=> !active_q);
  // R4
  win_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_o) |-> $past(arb_end_i));
  // R4
  win_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_arb_i && drv_o |-> bus0_i);
endmodule

// File: rtl/lp_arb_status.sv
module lp_arb_status
  import lp_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  phase_e     phase_i,
  input  logic       win_i,
  input  logic       stat_end_i,
  input  logic [1:0] bus_i,
  input  logic       err_i,
  output logic [1:0] drv_o,
  output logic       reject_o,
  output logic       acc_err_o
);
  logic rej_q, aerr_q;

  assign drv_o     = (phase_i == PH_STAT && win_i) ? 2'b11 : 2'b00;
  assign reject_o  = rej_q;
  assign acc_err_o = aerr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rej_q  <= 1'b0;
      aerr_q <= 1'b0;
    end else begin
      if (clr_i) rej_q <= 1'b0;
      else if (stat_end_i) rej_q <= (bus_i == 2'b00);
      if (stat_end_i && err_i) aerr_q <= 1'b1;
    end
  end

  // R8
  acc_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |=> acc_err_o);
  // R7
  reject_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reject_o) |-> $past(stat_end_i));
  // R7
  reject_vs_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reject_o && win_i));
endmodule

// File: rtl/lp_arb_agent.sv
module lp_arb_agent
  import lp_arb_pkg::*;
#(
  parameter int PRIO_W    = 8,
  parameter int ID_W      = 4,
  parameter int ARB_FIRST = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              msg_start_i,
  input  logic              free_slot_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [ID_W-1:0]   arb_id_i,
  input  logic [1:0]        bus_i,
  input  logic              accept_err_i,
  output logic [1:0]        bus_drv_o,
  output logic              win_o,
  output logic              reject_o,
  output logic              accept_err_o
);
  phase_e     phase;
  logic       arm, arb_stb, arb_end, stat_end, clr;
  logic       arb_bit, win;
  logic [1:0] stat_drv;

  lp_arb_cycle #(.ARB_FIRST(ARB_FIRST), .ARB_BITS(PRIO_W + ID_W)) u_cycle (
    .clk_i, .rst_ni, .bit_stb_i, .msg_start_i,
    .phase_o(phase), .arm_o(arm), .arb_stb_o(arb_stb),
    .arb_end_o(arb_end), .stat_end_o(stat_end), .clr_o(clr)
  );

  lp_arb_serial #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_serial (
    .clk_i, .rst_ni, .clr_i(clr), .arm_i(arm), .arb_stb_i(arb_stb),
    .arb_end_i(arb_end), .in_arb_i(phase == PH_ARB), .free_i(free_slot_i),
    .prio_i, .id_i(arb_id_i), .bus0_i(bus_i[0]),
    .drv_o(arb_bit), .win_o(win)
  );

  lp_arb_status u_status (
    .clk_i, .rst_ni, .clr_i(clr), .phase_i(phase), .win_i(win),
    .stat_end_i(stat_end), .bus_i, .err_i(accept_err_i),
    .drv_o(stat_drv), .reject_o, .acc_err_o(accept_err_o)
  );

  assign bus_drv_o = {stat_drv[1], stat_drv[0] | arb_bit};
  assign win_o     = win;

  // R3
  wire1_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase != PH_STAT |-> !bus_drv_o[1]);
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE || phase == PH_HEAD || phase == PH_TAIL) |-> bus_drv_o == 2'b00);
  // R6
  stat_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_STAT && bus_drv_o != 2'b00 |-> win_o);
endmodule

// File: tb/lp_arb_agent_test.sv
module lp_arb_agent_test;
  localparam int N  = 4;
  localparam int PW = 8;
  localparam int IW = 4;
  localparam int AB = PW + IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic stb = 1'b0, start = 1'b0, err = 1'b0;
  logic [N-1:0]  free;
  logic [PW-1:0] prio [N];
  logic [IW-1:0] id   [N];
  logic [1:0]    drv  [N];
  logic [N-1:0]  win, rej, aerr;
  logic [1:0]    bus;

  always_comb begin
    bus = 2'b00;
    for (int i = 0; i < N; i++) bus = bus | drv[i];
  end

  for (genvar g = 0; g < N; g++) begin : g_node
    lp_arb_agent uut (
      .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(stb), .msg_start_i(start),
      .free_slot_i(free[g]), .prio_i(prio[g]), .arb_id_i(id[g]),
      .bus_i(bus), .accept_err_i(err), .bus_drv_o(drv[g]),
      .win_o(win[g]), .reject_o(rej[g]), .accept_err_o(aerr[g])
    );
  end

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit exp_aerr = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit st);
    @(negedge clk);
    stb = 1'b1; start = st;
    @(posedge clk);
    #1 stb = 1'b0; start = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [AB-1:0] pat(input logic [PW-1:0] p, input logic [IW-1:0] d);
    return {~p, d};
  endfunction

  task automatic set_ids(input logic [IW-1:0] base);
    for (int i = 0; i < N; i++) id[i] = base + IW'(3 * i);
  endtask

  task automatic scramble();
    for (int i = 0; i < N; i++) begin
      prio[i] = PW'($urandom);
      id[i]   = IW'($urandom);
    end
    free = N'($urandom);
  endtask

  task automatic run_msg(input bit do_err, input bit scr);
    logic [AB-1:0] best;
    int widx;
    bit any;
    logic [N-1:0] fr;
    any = 1'b0; widx = -1; best = '0; fr = free;
    for (int i = 0; i < N; i++)
      if (free[i] && (!any || pat(prio[i], id[i]) > best)) begin
        any = 1'b1; best = pat(prio[i], id[i]); widx = i;
      end
    for (int c = 1; c <= 34; c++) begin
      step(c == 1);
      if (c == 1) begin
        chk("R10 win cleared", 32'(win), 0);
        chk("R10 reject cleared", 32'(rej), 0);
      end
      if (c < 21 || c == 34) chk("R2 quiet bus", 32'(bus), 0);
      else if (c <= 32) begin
        chk("R4 resolved arb bit", 32'(bus), 32'({1'b0, best[AB-1-(c-21)]}));
        for (int i = 0; i < N; i++)
          if (!fr[i]) chk("R5 busy node silent", 32'(drv[i]), 0);
      end else begin
        for (int i = 0; i < N; i++)
          chk("R6 status drive", 32'(drv[i]), (any && i == widx) ? 3 : 0);
      end
      if (scr && c == 22) scramble();
      if (c == 33) err = do_err;
      if (c == 34) err = 1'b0;
    end
    step(1'b0);
    exp_aerr = exp_aerr | do_err;
    for (int i = 0; i < N; i++) begin
      chk("R4 win", 32'(win[i]), 32'(any && i == widx));
      chk("R7 reject", 32'(rej[i]), 32'(!any));
      chk("R8 accept error", 32'(aerr[i]), 32'(exp_aerr));
    end
    repeat (3) @(negedge clk);
    chk("R4 win held", 32'(win[widx < 0 ? 0 : widx]), 32'(any));
  endtask

  initial begin
    void'($urandom(32'd77));
    free = '0;
    for (int i = 0; i < N; i++) prio[i] = '0;
    set_ids(4'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++) chk("R1 reset drive", 32'(drv[i]), 0);
    chk("R1 reset win", 32'(win), 0);
    chk("R1 reset reject", 32'(rej), 0);
    chk("R1 reset aerr", 32'(aerr), 0);

    // R3: lone participant, bus equals its own pattern
    prio[0] = 8'h5a; prio[1] = 8'h01; prio[2] = 8'h02; prio[3] = 8'h03;
    set_ids(4'd9); free = 4'b0001;
    run_msg(1'b0, 1'b0);
    // R3: lone all-zero pattern still wins
    prio[2] = 8'hff; id[2] = 4'd0; free = 4'b0100;
    run_msg(1'b0, 1'b0);
    // R4: equal priorities, ID breaks tie
    for (int i = 0; i < N; i++) prio[i] = 8'h33;
    set_ids(4'd2); free = 4'b1111;
    run_msg(1'b0, 1'b0);
    // R7: nobody free
    free = 4'b0000;
    run_msg(1'b0, 1'b0);
    // R9: scramble during arbitration
    prio[0] = 8'h10; prio[1] = 8'h80; prio[2] = 8'h04; prio[3] = 8'h40;
    set_ids(4'd5); free = 4'b1011;
    run_msg(1'b0, 1'b1);
    // R10: restart mid-message
    prio[0] = 8'h20; prio[1] = 8'h08; prio[2] = 8'h90; prio[3] = 8'h08;
    set_ids(4'd1); free = 4'b1111;
    step(1'b1);
    for (int c = 2; c <= 25; c++) step(1'b0);
    run_msg(1'b0, 1'b0);
    // random
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < N; i++) prio[i] = PW'($urandom);
      if (k % 5 == 0) for (int i = 0; i < N; i++) prio[i] = prio[0];
      set_ids(IW'($urandom));
      free = N'($urandom);
      run_msg(1'b0, k % 3 == 0);
    end
    // R8: error then sticky across next messages
    free = 4'b0110;
    run_msg(1'b1, 1'b0);
    free = 4'b0000;
    run_msg(1'b0, 1'b0);
    free = 4'b1001;
    run_msg(1'b0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule